// File: doc/BRIEF.md
# Mode-Configurable Product-Term Logic Array

This block models a small programmable AND-OR array with eight output macrocells. It has a set of dedicated input pins and eight bidirectional pins. The bidirectional pins appear as three separate buses: the pin value coming in, the value driven out, and a drive enable. A configuration image supplies three things: the fuse bits of the AND plane, one inversion bit per macrocell, and a direction bit per macrocell. A global mode bit chooses between a simple and a complex way of sharing the product terms.

Every product term is the AND of the array literals whose fuse bit is set. Each array input offers two literals, its true value and its complement. The array inputs are the dedicated pins followed by one feedback line per macrocell. In simple mode a macrocell ORs all of its terms, and the direction bit fixes its enable. In complex mode the first term of each macrocell becomes its enable term, and the rest are ORed. The mode also decides which macrocells feed their pin value back into the array. Outputs and enables are registered once, so the pins follow the inputs after one clock.

Top module: `pal_logic_array`

## Requirements
- R1: While `rst` is high at a rising clock edge, `io_out` and `io_oe` are cleared to all zeros.
- R2: Array input j is `ded_in[j]` for j below N_DED, and feedback line k is array input N_DED+k. Literal 2j is the true value of array input j and literal 2j+1 is its complement. Fuse bit ((m*PT_PER_MC+t)*2*(N_DED+N_MC)+l) of `cfg_fuse` connects literal l to term t of macrocell m. A term is the AND of its connected literals.
- R3: A term with no fuse set evaluates to 1. A term that connects both literals of one array input evaluates to 0.
- R4: In simple mode (`cfg_complex`=0), the sum of a macrocell is the OR of all its PT_PER_MC terms.
- R5: In complex mode (`cfg_complex`=1), the enable of a macrocell equals its term 0. Its sum is the OR of terms 1 to PT_PER_MC-1, and term 0 does not take part in the sum.
- R6: `io_out[m]` is the sum of macrocell m when `cfg_invert[m]`=0, and its complement when `cfg_invert[m]`=1.
- R7: In simple mode, the two centre macrocells (N_MC/2-1 and N_MC/2) always have their enable at 1, and their feedback lines read 0.
- R8: In simple mode, every other macrocell has enable = NOT `cfg_dir_in[m]`, and its feedback line carries `io_in[m]`.
- R9: In complex mode, the outermost macrocells (0 and N_MC-1) have feedback lines that read 0. The inner macrocells feed back `io_in`.
- R10: `io_out` and `io_oe` change only at a rising clock edge. They reflect the inputs present one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fuse | input | N_MC*PT_PER_MC*2*(N_DED+N_MC) | AND-plane fuse image |
| cfg_invert | input | N_MC | Per-macrocell output inversion |
| cfg_complex | input | 1 | 1 selects complex mode, 0 simple mode |
| cfg_dir_in | input | N_MC | Simple mode: 1 makes the macrocell an input |
| ded_in | input | N_DED | Dedicated input pins |
| io_in | input | N_MC | Value seen on the bidirectional pins |
| io_out | output | N_MC | Registered value to drive on the pins |
| io_oe | output | N_MC | Registered drive enable per pin |

## Verification
The bench builds the block with its defaults: 12 dedicated inputs, 8 macrocells and 8 terms per macrocell, which gives 2560 fuse bits. With these values the outer cells (0, 7) and the centre cells (3, 4) are distinct positions. Each of the four mode-dependent feedback rules can therefore be reached on its own. Sparse random fuse images exercise many literal combinations across all 20 array inputs. Directed images route a single feedback line into another cell, so that a gated line shows up directly on an output.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int DEF_N_DED = 12;
  localparam int DEF_N_MC  = 8;
  localparam int DEF_PT    = 8;

  function automatic logic is_centre(input int idx, input int n_mc);
    return (idx == n_mc/2 - 1) || (idx == n_mc/2);
  endfunction

  function automatic logic is_outer(input int idx, input int n_mc);
    return (idx == 0) || (idx == n_mc - 1);
  endfunction
endpackage

// File: rtl/pal_feedback.sv
module pal_feedback #(
  parameter int N_DED = 12,
  parameter int N_MC  = 8
) (
  input  logic                  cplx,
  input  logic [N_DED-1:0]      ded_in,
  input  logic [N_MC-1:0]       io_in,
  output logic [N_DED+N_MC-1:0] arr_in
);
  logic [N_MC-1:0] fb;

  for (genvar k = 0; k < N_MC; k++) begin : g_fb
    if (pal_pkg::is_outer(k, N_MC)) begin : g_outer
      // complex mode: outer cells are output-only
      assign fb[k] = cplx ? 1'b0 : io_in[k];
    end else if (pal_pkg::is_centre(k, N_MC)) begin : g_centre
      // simple mode: centre cells are fixed outputs without feedback
      assign fb[k] = cplx ? io_in[k] : 1'b0;
    end else begin : g_inner
      assign fb[k] = io_in[k];
    end
  end

  assign arr_in = {fb, ded_in};
endmodule

// File: rtl/pal_term_plane.sv
module pal_term_plane #(
  parameter int N_IN    = 20,
  parameter int N_TERMS = 8,
  localparam int N_LIT  = 2 * N_IN
) (
  input  logic [N_IN-1:0]          arr_in,
  input  logic [N_TERMS*N_LIT-1:0] fuse,
  output logic [N_TERMS-1:0]       terms
);
  logic [N_LIT-1:0] lits;

  for (genvar j = 0; j < N_IN; j++) begin : g_lit
    assign lits[2*j]   = arr_in[j];
    assign lits[2*j+1] = ~arr_in[j];
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    // unconnected literals count as true; an empty term is 1
    assign terms[t] = &(~fuse[t*N_LIT +: N_LIT] | lits);
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int PT    = 8,
  parameter int INDEX = 0,
  parameter int N_MC  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cplx,
  input  logic          dir_in,
  input  logic          invert,
  input  logic [PT-1:0] terms,
  output logic          out_q,
  output logic          oe_q
);
  localparam logic CENTRE = pal_pkg::is_centre(INDEX, N_MC);

  logic sum_all, sum_rest, sum, oe_n, out_n;

  assign sum_all  = |terms;
  assign sum_rest = |terms[PT-1:1];
  assign sum      = cplx ? sum_rest : sum_all;
  assign oe_n     = cplx ? terms[0] : (CENTRE | ~dir_in);
  assign out_n    = sum ^ invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_n;
      oe_q  <= oe_n;
    end
  end

  p_simple_all_terms_r4: assert property (@(posedge clk) disable iff (rst)
    (!cplx && terms == '0) |=> (out_q == $past(invert)));
  p_cplx_oe_term_r5: assert property (@(posedge clk) disable iff (rst)
    (cplx && !terms[0]) |=> !oe_q);
  p_cplx_sum_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (cplx && terms[PT-1:1] == '0) |=> (out_q == $past(invert)));

  if (CENTRE) begin : g_chk_centre
    p_centre_drive_r7: assert property (@(posedge clk) disable iff (rst)
      !cplx |=> oe_q);
  end else begin : g_chk_side
    p_dir_input_r8: assert property (@(posedge clk) disable iff (rst)
      (!cplx && dir_in) |=> !oe_q);
  end
endmodule

// File: rtl/pal_logic_array.sv
module pal_logic_array #(
  parameter int N_DED     = pal_pkg::DEF_N_DED,
  parameter int N_MC      = pal_pkg::DEF_N_MC,
  parameter int PT_PER_MC = pal_pkg::DEF_PT
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [N_MC*PT_PER_MC*2*(N_DED+N_MC)-1:0]   cfg_fuse,
  input  logic [N_MC-1:0]                             cfg_invert,
  input  logic                                        cfg_complex,
  input  logic [N_MC-1:0]                             cfg_dir_in,
  input  logic [N_DED-1:0]                            ded_in,
  input  logic [N_MC-1:0]                             io_in,
  output logic [N_MC-1:0]                             io_out,
  output logic [N_MC-1:0]                             io_oe
);
  localparam int N_IN    = N_DED + N_MC;
  localparam int N_LIT   = 2 * N_IN;
  localparam int MC_FUSE = PT_PER_MC * N_LIT;

  logic [N_IN-1:0] arr_in;

  pal_feedback #(.N_DED(N_DED), .N_MC(N_MC)) fb_i (
    .cplx   (cfg_complex),
    .ded_in (ded_in),
    .io_in  (io_in),
    .arr_in (arr_in)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic [PT_PER_MC-1:0] terms;

    pal_term_plane #(.N_IN(N_IN), .N_TERMS(PT_PER_MC)) plane_i (
      .arr_in (arr_in),
      .fuse   (cfg_fuse[m*MC_FUSE +: MC_FUSE]),
      .terms  (terms)
    );

    pal_macrocell #(.PT(PT_PER_MC), .INDEX(m), .N_MC(N_MC)) cell_i (
      .clk    (clk),
      .rst    (rst),
      .cplx   (cfg_complex),
      .dir_in (cfg_dir_in[m]),
      .invert (cfg_invert[m]),
      .terms  (terms),
      .out_q  (io_out[m]),
      .oe_q   (io_oe[m])
    );
  end
endmodule

// File: tb/pal_logic_array_tb.sv
module pal_logic_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 12;
  localparam int NM = 8;
  localparam int PT = 8;
  localparam int NL = 2 * (ND + NM);
  localparam int FW = NM * PT * NL;

  logic clk = 1'b0;
  logic rst;
  logic [FW-1:0] cfg_fuse;
  logic [NM-1:0] cfg_invert, cfg_dir_in, io_in, io_out, io_oe;
  logic cfg_complex;
  logic [ND-1:0] ded_in;

  // stimulus staged here, applied at the next falling edge
  logic [FW-1:0] s_fuse;
  logic [NM-1:0] s_inv, s_dir, s_io;
  logic s_cplx;
  logic [ND-1:0] s_ded;

  logic [NM-1:0] exp_out, exp_oe;
  logic have_exp = 1'b0;
  string exp_tag = "";
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_logic_array #(.N_DED(ND), .N_MC(NM), .PT_PER_MC(PT)) dut_i (
    .clk(clk), .rst(rst), .cfg_fuse(cfg_fuse), .cfg_invert(cfg_invert),
    .cfg_complex(cfg_complex), .cfg_dir_in(cfg_dir_in), .ded_in(ded_in),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe));

  function automatic int fidx(int m, int t, int l);
    return (m * PT + t) * NL + l;
  endfunction

  // behavioural evaluation of the requirements
  task automatic model(output logic [NM-1:0] o, output logic [NM-1:0] e);
    logic [ND+NM-1:0] a;
    for (int j = 0; j < ND; j++) a[j] = s_ded[j];
    for (int k = 0; k < NM; k++) begin
      if (s_cplx && (k == 0 || k == NM-1)) a[ND+k] = 1'b0;
      else if (!s_cplx && (k == NM/2-1 || k == NM/2)) a[ND+k] = 1'b0;
      else a[ND+k] = s_io[k];
    end
    for (int m = 0; m < NM; m++) begin
      logic sum = 1'b0;
      logic t0 = 1'b1;
      for (int t = 0; t < PT; t++) begin
        logic v = 1'b1;
        for (int j = 0; j < ND + NM; j++) begin
          if (s_fuse[fidx(m, t, 2*j)] && !a[j]) v = 1'b0;
          if (s_fuse[fidx(m, t, 2*j+1)] && a[j]) v = 1'b0;
        end
        if (t == 0) t0 = v;
        if (!(s_cplx && t == 0)) sum = sum | v;
      end
      o[m] = sum ^ s_inv[m];
      if (s_cplx) e[m] = t0;
      else if (m == NM/2-1 || m == NM/2) e[m] = 1'b1;
      else e[m] = ~s_dir[m];
    end
  endtask

  task automatic check(string tag, logic [NM-1:0] got_o, logic [NM-1:0] got_e,
                       logic [NM-1:0] want_o, logic [NM-1:0] want_e);
    n_chk++;
    if (got_o !== want_o || got_e !== want_e) begin
      n_bad++;
      $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b", tag, got_o, got_e, want_o, want_e);
    end
  endtask

  task automatic step(string tag);
    logic [NM-1:0] no, ne;
    @(negedge clk);
    if (have_exp) check(exp_tag, io_out, io_oe, exp_out, exp_oe);
    cfg_fuse = s_fuse; cfg_invert = s_inv; cfg_dir_in = s_dir;
    cfg_complex = s_cplx; ded_in = s_ded; io_in = s_io; rst = 1'b0;
    model(no, ne);
    #1;
    // R10: nothing moves before the next rising edge
    if (have_exp) check("R10 hold", io_out, io_oe, exp_out, exp_oe);
    exp_out = no; exp_oe = ne; exp_tag = tag; have_exp = 1'b1;
  endtask

  task automatic rand_fuse();
    for (int i = 0; i < FW; i++) s_fuse[i] = ($urandom_range(23) == 0);
  endtask

  task automatic rand_pins();
    s_ded = ND'($urandom);
    s_io  = NM'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cfg_fuse = '0; cfg_invert = '1; cfg_dir_in = '0; cfg_complex = 1'b0;
    ded_in = '1; io_in = '1;
    s_fuse = '0; s_inv = '0; s_dir = '0; s_cplx = 1'b0; s_ded = '0; s_io = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", io_out, io_oe, '0, '0);

    // empty terms: simple active-high, then inverted (R3 R4 R6)
    step("R3 empty simple");
    step("R3 empty simple");
    s_inv = '1; step("R6 empty inverted");
    s_cplx = 1'b1; s_inv = '0; step("R5 empty complex");

    // both literals of one input connected
    s_fuse = '0;
    for (int m = 0; m < NM; m++)
      for (int t = 0; t < PT; t++) begin
        s_fuse[fidx(m, t, 2*(m % ND))] = 1'b1;
        s_fuse[fidx(m, t, 2*(m % ND) + 1)] = 1'b1;
      end
    s_cplx = 1'b0; step("R3 contradiction simple");
    s_cplx = 1'b1; step("R3 contradiction complex");

    // complex: outer feedback gated, inner fed back (R9)
    s_fuse = '1;
    s_fuse[fidx(2, 1, 0) +: NL] = '0; s_fuse[fidx(2, 1, 2*(ND+0))] = 1'b1;
    s_fuse[fidx(3, 1, 0) +: NL] = '0; s_fuse[fidx(3, 1, 2*(ND+1))] = 1'b1;
    s_fuse[fidx(5, 1, 0) +: NL] = '0; s_fuse[fidx(5, 1, 2*(ND+NM-1)+1)] = 1'b1;
    for (int m = 0; m < NM; m++) s_fuse[fidx(m, 0, 0) +: NL] = '0;
    s_cplx = 1'b1; s_inv = '0;
    s_io = '1; step("R9 outer gated io=1");
    s_io = '0; step("R9 outer gated io=0");
    s_io = 8'h02; step("R9 inner feedback");

    // simple: centre feedback gated, side feedback live (R7 R8)
    s_fuse = '1;
    for (int m = 0; m < NM; m++) s_fuse[fidx(m, 0, 0) +: NL] = {NL{1'b1}};
    s_fuse[fidx(1, 0, 0) +: NL] = '0; s_fuse[fidx(1, 0, 2*(ND+NM/2))] = 1'b1;
    s_fuse[fidx(6, 0, 0) +: NL] = '0; s_fuse[fidx(6, 0, 2*(ND+0))] = 1'b1;
    s_cplx = 1'b0; s_dir = 8'b1000_0001;
    s_io = '1; step("R7 centre no feedback");
    s_io = 8'h01; step("R8 side feedback");
    s_dir = '1; step("R7 centre forced output");

    // random device images: active-high, active-low, mixed polarity
    for (int ph = 0; ph < 6; ph++) begin
      rand_fuse();
      s_cplx = ph[0];
      s_inv = (ph < 2) ? '0 : (ph < 4) ? '1 : NM'($urandom);
      for (int c = 0; c < 60; c++) begin
        rand_pins();
        s_dir = NM'($urandom);
        step(s_cplx ? "R2 R5 R9 random complex" : "R2 R4 R8 random simple");
      end
    end

    // mode flips on the same image
    rand_fuse();
    for (int c = 0; c < 40; c++) begin
      rand_pins();
      s_cplx = c[0];
      s_inv = NM'($urandom);
      step("R10 mode toggle");
    end

    // reset in the middle of activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", io_out, io_oe, '0, '0);
    have_exp = 1'b0;
    step("R10 after reset");
    step("R10 after reset");

    @(negedge clk);
    check(exp_tag, io_out, io_oe, exp_out, exp_oe);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule